// File: doc/BRIEF.md
# Timer Count-Enable Generator and Counter

This block makes the count enable for one timer channel and advances a 16-bit counter with it. Everything is clocked by a single system clock. A free-running prescaler produces single-cycle strobes at the system clock divided by 2^e, for e from 1 to 15. Exponent 0 selects a constant-high enable, which is the undivided clock.

Four configurable tap slots each hold a division exponent. A 2-bit select picks one slot as the operating clock. A source-select bit then chooses between that operating clock and a strobe taken from the timer input pin. The pin strobe is produced after a two-flop synchronizer and an edge detector whose mode is programmable.

The chosen strobe is registered onto `count_en`. On the following clock edge the counter moves by one, if `start` is high. This keeps every update one system cycle behind the count-clock edge.

Top module: `tmr_count_unit`

## Requirements
- R1: While `rst` is high, on every clock edge `count` is cleared to 0 and `count_en` to 0. The prescaler, synchronizer and edge detector are cleared as well.
- R2: With `src_sel`=0 and a selected exponent e between 1 and 15, `count_en` is high for exactly one cycle after edge n, where n counts clock edges since `rst` fell (first edge is n=1), and n is a multiple of 2^e. It is low after every other edge.
- R3: With `src_sel`=0 and a selected exponent of 0, `count_en` is high after every edge from the first edge following reset.
- R4: Slot i of the operating-clock choice is `tap_cfg[4*i+3:4*i]`, selected by `clk_sel`=i. With `src_sel`=1 the tap selection has no effect and only the pin strobe drives `count_en`.
- R5: `count` increases by one on the clock edge after an edge that set `count_en` high, when `start` is high at that edge.
- R6: A change of `tin` first sampled at edge a produces `count_en` high after edge a+2, for one cycle. The count then moves at edge a+3.
- R7: `edge_mode` encoding: 2'b00 counts rising edges of `tin`, 2'b01 counts falling edges, and 2'b10 counts both.
- R8: With `edge_mode`=2'b11, transitions of `tin` never raise `count_en` while `src_sel`=1.
- R9: While `start` is low at a clock edge, `count` keeps its value even if `count_en` is high.
- R10: `count` wraps from 16'hFFFF to 16'h0000 on an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Counter run enable |
| clk_sel | input | 2 | Selects one of four tap slots as operating clock |
| src_sel | input | 1 | 0: operating clock, 1: timer-pin edge |
| tap_cfg | input | 16 | Four 4-bit division exponents, slot i at bits 4i+3:4i |
| edge_mode | input | 2 | Pin edge mode: rise, fall, both, off |
| tin | input | 1 | Asynchronous timer input pin |
| count_en | output | 1 | Registered count-clock strobe |
| count | output | 16 | Counter value |

## Verification
The bench targets the tap boundaries. At exponent 15 the first strobe must land on edge 32768 exactly; a design with the tap built from the wrong prescaler bit would strobe at half or double that interval or on the wrong phase. It runs the divide-by-1 selection across a full wrap of the counter, where a slip in the enable or in the wrap would show as a gap or a stuck value. Pin tests toggle `tin` in each edge mode and require the strobe exactly two edges after sampling; a missing or extra synchronizer stage, a wrong polarity, or a pin strobe leaking through the constant-high tap would shift or multiply the counts. Dropping `start` mid-run must freeze the count while the enable keeps pulsing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic           clk,
  input  logic           rst,
  output logic [PRE_W:0] tap_hit
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // tap 0 is the undivided clock: always enabled
  assign tap_hit[0] = 1'b1;

  // tap k fires when the low k bits are all ones, one cycle before bit k rises
  genvar k;
  generate
    for (k = 1; k <= PRE_W; k++) begin : g_tap
      assign tap_hit[k] = &pre_q[k-1:0];
    end
  endgenerate

  // R2: the prescaler advances by exactly one per cycle out of reset
  p_pre_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pre_q == PRE_W'($past(pre_q) + 1'b1));
endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
  import tmr_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tin,
  input  edge_mode_e mode,
  output logic       pin_hit
);
  // sh_q[SYNC_N-1] is the synchronized pin, sh_q[SYNC_N] its previous value
  logic [SYNC_N:0] sh_q;
  logic            rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_N-1:0], tin};
  end

  assign rise = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
  assign fall = ~sh_q[SYNC_N-1] & sh_q[SYNC_N];

  always_comb begin
    case (mode)
      EDGE_RISE: pin_hit = rise;
      EDGE_FALL: pin_hit = fall;
      EDGE_BOTH: pin_hit = rise | fall;
      default:   pin_hit = 1'b0;
    endcase
  end

  // R7: a rising-edge strobe can never last two cycles
  p_rise_single_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_hit) && $past(mode) == EDGE_RISE && mode == EDGE_RISE)
      |-> !pin_hit);
endmodule

// File: rtl/tmr_clk_select.sv
module tmr_clk_select #(
  parameter int PRE_W = 15,
  parameter int EXP_W = 4,
  parameter int NSLOT = 4,
  localparam int SEL_W = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PRE_W:0]         tap_hit,
  input  logic [SEL_W-1:0]       clk_sel,
  input  logic [NSLOT*EXP_W-1:0] tap_cfg,
  input  logic                   src_sel,
  input  logic                   pin_hit,
  output logic                   tclk
);
  logic [EXP_W-1:0] exp_sel;
  logic             op_clk;

  assign exp_sel = tap_cfg[clk_sel*EXP_W +: EXP_W];
  assign op_clk  = tap_hit[exp_sel];
  assign tclk    = src_sel ? pin_hit : op_clk;

  // R3: exponent 0 on the operating clock keeps the enable high
  p_div1_high_r3: assert property (@(posedge clk) disable iff (rst)
    (!src_sel && exp_sel == '0) |-> tclk);

  // R2: a divided tap strobe lasts one cycle under a stable selection
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_clk) && $past(exp_sel) != '0 && exp_sel == $past(exp_sel))
      |-> !op_clk);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start && en) cnt <= cnt + 1'b1;
  end

  // R9: start low freezes the counter
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start)) |-> cnt == $past(cnt));

  // R10: every increment is by one modulo 2^CNT_W, so all-ones wraps to zero
  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(start) && $past(en)) |-> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 15,
  parameter int EXP_W  = 4,
  parameter int NSLOT  = 4,
  parameter int SYNC_N = 2,
  localparam int SEL_W = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [SEL_W-1:0]       clk_sel,
  input  logic                   src_sel,
  input  logic [NSLOT*EXP_W-1:0] tap_cfg,
  input  logic [1:0]             edge_mode,
  input  logic                   tin,
  output logic                   count_en,
  output logic [CNT_W-1:0]       count
);
  logic [PRE_W:0] tap_hit;
  logic           pin_hit;
  logic           tclk;
  edge_mode_e     mode;

  assign mode = edge_mode_e'(edge_mode);

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tap_hit(tap_hit)
  );

  tmr_pin_edge #(.SYNC_N(SYNC_N)) u_pin (
    .clk(clk), .rst(rst), .tin(tin), .mode(mode), .pin_hit(pin_hit)
  );

  tmr_clk_select #(.PRE_W(PRE_W), .EXP_W(EXP_W), .NSLOT(NSLOT)) u_sel (
    .clk(clk), .rst(rst), .tap_hit(tap_hit), .clk_sel(clk_sel),
    .tap_cfg(tap_cfg), .src_sel(src_sel), .pin_hit(pin_hit), .tclk(tclk)
  );

  // registered count clock: the counter acts one cycle after the strobe edge
  always_ff @(posedge clk) begin
    if (rst) count_en <= 1'b0;
    else     count_en <= tclk;
  end

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .en(count_en), .cnt(count)
  );

  // R8: with the pin detector off and the pin selected, no strobe appears
  p_pin_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(src_sel) && $past(mode) == EDGE_OFF) |-> !count_en);
endmodule

// File: tb/tb_tmr_count_unit.sv
module tb_tmr_count_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  clk_sel = 2'd0;
  logic        src_sel = 1'b0;
  logic [15:0] tap_cfg = 16'h0000;
  logic [1:0]  edge_mode = 2'b00;
  logic        tin = 1'b0;
  logic        count_en;
  logic [15:0] count;

  always #10 clk = ~clk;

  tmr_count_unit dut (
    .clk(clk), .rst(rst), .start(start), .clk_sel(clk_sel), .src_sel(src_sel),
    .tap_cfg(tap_cfg), .edge_mode(edge_mode), .tin(tin),
    .count_en(count_en), .count(count)
  );

  typedef struct {
    logic [15:0] cnt;
    logic        en;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [15:0] m_cnt;
  logic        m_en_prev;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each registered result half a cycle after its edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check({it.tag, " count"}, 32'(count), 32'(it.cnt));
      check({it.tag, " count_en"}, 32'(count_en), 32'(it.en));
    end
  end

  // driver: predict the state after the next edge and push it
  task automatic step(logic exp_en, string tag);
    if (start && m_en_prev) m_cnt = m_cnt + 16'd1;
    m_en_prev = exp_en;
    @(posedge clk);
    sb_q.push_back('{cnt: m_cnt, en: exp_en, tag: tag});
  endtask

  task automatic do_reset(logic [1:0] sel, logic src, logic [1:0] mode, logic run);
    @(negedge clk);
    rst = 1'b1; clk_sel = sel; src_sel = src; edge_mode = mode;
    start = run; tin = 1'b0;
    tap_cfg = {4'd15, 4'd5, 4'd3, 4'd0};
    @(posedge clk);
    @(negedge clk);
    check("R1 reset count", 32'(count), 32'd0);
    check("R1 reset count_en", 32'(count_en), 32'd0);
    rst = 1'b0;
    m_cnt = 16'd0;
    m_en_prev = 1'b0;
  endtask

  task automatic periodic(int e, int n, string tag);
    for (int m = 1; m <= n; m++) step((m % (1 << e)) == 0, tag);
  endtask

  task automatic pin_toggle(logic val, logic hit, string tag);
    @(negedge clk);
    tin = val;
    step(1'b0, tag);
    step(1'b0, tag);
    step(hit, tag);
    step(1'b0, tag);
    step(1'b0, tag);
  endtask

  task automatic drain;
    @(negedge clk);
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    // R2 R4: slot 1 holds exponent 3 (divide by 8)
    do_reset(2'd1, 1'b0, 2'b00, 1'b1);
    periodic(3, 40, "R2 R4 R5 div8");
    drain();
    // R2: slot 2 holds exponent 5 (divide by 32)
    do_reset(2'd2, 1'b0, 2'b00, 1'b1);
    periodic(5, 100, "R2 R5 div32");
    drain();
    // R2: slot 3 holds exponent 15, first strobe after edge 32768
    do_reset(2'd3, 1'b0, 2'b00, 1'b1);
    periodic(15, 32772, "R2 div32768");
    drain();
    // R9: start low freezes the count while the enable keeps running
    do_reset(2'd0, 1'b0, 2'b00, 1'b1);
    periodic(0, 5, "R3 R5 run");
    @(negedge clk); start = 1'b0;
    periodic(0, 6, "R9 hold");
    @(negedge clk); start = 1'b1;
    periodic(0, 4, "R9 resume");
    drain();
    // R6 R7 rising; constant-high tap is ignored with the pin selected (R4)
    do_reset(2'd0, 1'b1, 2'b00, 1'b1);
    step(1'b0, "R4 pin idle");
    pin_toggle(1'b1, 1'b1, "R6 R7 rise up");
    pin_toggle(1'b0, 1'b0, "R7 rise down");
    pin_toggle(1'b1, 1'b1, "R6 R7 rise up2");
    drain();
    // R7 falling
    do_reset(2'd0, 1'b1, 2'b01, 1'b1);
    pin_toggle(1'b1, 1'b0, "R7 fall up");
    pin_toggle(1'b0, 1'b1, "R7 fall down");
    drain();
    // R7 both edges
    do_reset(2'd0, 1'b1, 2'b10, 1'b1);
    pin_toggle(1'b1, 1'b1, "R7 both up");
    pin_toggle(1'b0, 1'b1, "R7 both down");
    drain();
    // R8 detector off
    do_reset(2'd0, 1'b1, 2'b11, 1'b1);
    pin_toggle(1'b1, 1'b0, "R8 off up");
    pin_toggle(1'b0, 1'b0, "R8 off down");
    drain();
    // R3 R10: divide by 1 across a full wrap of the counter
    do_reset(2'd0, 1'b0, 2'b00, 1'b1);
    periodic(0, 65540, "R3 R10 wrap");
    drain();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule